// File: doc/BRIEF.md
# Arithmetic Operand Test Pattern Generator

This block produces, on chip and at the full functional clock rate, a fixed ordered set of sixteen operand pairs for exercising an embedded adder or multiplier during self-test. Each pair drives two operand buses, A and B. Each operand is one of four uniform words: all zeros, all ones, or one of two strictly alternating bit patterns. The whole sequence comes from a two-bit step counter and a two-bit group counter followed by a small combinational decoder. No table of full-width vectors is stored.

A start pulse arms the generator and rewinds it to the first pair. While enable is high, one pair is issued on every clock, with a valid flag and a four-bit index that names the pair now on the buses. Dropping enable freezes the sequence. One cycle after the last pair, a done flag rises and the buses return to zero until the next start. The operand width is a parameter and must be even and at least 4.

Top module: `arith_pattern_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, both operand buses, the index, valid and done are all zero.
- R2: A start pulse rewinds the sequence at any point, including mid-sequence. In the cycle after the start edge, valid and done are low, the index is 0 and both buses are zero. The next enabled edge issues index 0.
- R3: At each clock edge where the generator is running and enable is high, it issues exactly one new pair. Valid is high in the following cycle, and the index is one more than that of the previous issued pair.
- R4: At an edge where enable is low, the generator issues no pair. In the following cycle valid is low, and the index and both operand buses keep their values.
- R5: Pairs are issued in index order 0..15 as (A,B), with Z=zeros, O=ones, P=alternating with bit 0 set, Q=alternating with bit 1 set: (Z,Z) (Z,O) (O,Z) (O,O) (P,P) (Q,Q) (P,Q) (Q,P) (P,Z) (P,O) (O,P) (Z,P) (Q,Z) (Q,O) (O,Q) (Z,Q).
- R6: The word encodings are as follows. Z has every bit 0 and O has every bit 1. P has bit i set exactly when i is even, so it reads 0x5 per nibble. Q has bit i set exactly when i is odd, so it reads 0xA per nibble. These hold at every supported width.
- R7: Done rises in the cycle right after the cycle showing index 15, whatever enable does. In that cycle valid is low and both buses are zero. Done then stays high until a start.
- R8: Whenever valid is high, the index names the pair currently on the operand buses.
- R9: Enable has no effect before the first start after reset, or after done. No pair is issued and valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Rewind and arm the sequence |
| enable_i | input | 1 | Advance one pair per clock while high |
| op_a_o | output | OPW | Operand A word |
| op_b_o | output | OPW | Operand B word |
| valid_o | output | 1 | A new pair is on the buses this cycle |
| index_o | output | 4 | Index of the pair on the buses |
| done_o | output | 1 | Sequence finished |

## Verification
The hardest situation to reach is a rewind that lands mid-sequence in the same cycle that enable is high. In that case start must win, and no partial pair may leak out before index 0 is issued again. The stimulus runs six enabled pairs, then raises start with enable still high. It then checks the quiet cycle after the start edge before running a full sequence. Enable gaps at several points check that the buses and index hold. Enable is also held high before any start and after done, to show that nothing is issued. Three widths (4, 8 and 16) run in parallel from the same stimulus.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   localparam int unsigned GRP_W  = 2;
   localparam int unsigned STEP_W = 2;
   localparam int unsigned IDX_W  = GRP_W + STEP_W;

   typedef enum logic [1:0] {
      W_ZERO   = 2'd0,
      W_ONE    = 2'd1,
      W_ALT_LO = 2'd2,
      W_ALT_HI = 2'd3
   } word_sel_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RUN  = 2'd1,
      S_TAIL = 2'd2,
      S_DONE = 2'd3
   } seq_state_e;
endpackage

// File: rtl/tpg_sequencer.sv
module tpg_sequencer
   import tpg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              enable_i,
   output logic              emit_o,
   output logic              tail_o,
   output logic [GRP_W-1:0]  grp_o,
   output logic [STEP_W-1:0] step_o
);
   localparam logic [GRP_W-1:0]  GRP_LAST  = '1;
   localparam logic [STEP_W-1:0] STEP_LAST = '1;

   seq_state_e       state_q;
   logic [GRP_W-1:0]  grp_q;
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         grp_q   <= '0;
         step_q  <= '0;
      end else if (start_i) begin
         state_q <= S_RUN;
         grp_q   <= '0;
         step_q  <= '0;
      end else begin
         unique case (state_q)
            S_RUN: begin
               if (enable_i) begin
                  step_q <= step_q + 1'b1;
                  if (step_q == STEP_LAST) begin
                     grp_q <= grp_q + 1'b1;
                     if (grp_q == GRP_LAST) state_q <= S_TAIL;
                  end
               end
            end
            S_TAIL:  state_q <= S_DONE;
            default: state_q <= state_q;
         endcase
      end
   end

   assign emit_o = (state_q == S_RUN) && enable_i && !start_i;
   assign tail_o = (state_q == S_TAIL) && !start_i;
   assign grp_o  = grp_q;
   assign step_o = step_q;
endmodule

// File: rtl/tpg_pair_decoder.sv
module tpg_pair_decoder
   import tpg_pkg::*;
(
   input  logic [GRP_W-1:0]  grp_i,
   input  logic [STEP_W-1:0] step_i,
   output word_sel_e         sel_a_o,
   output word_sel_e         sel_b_o
);
   word_sel_e alt;

   always_comb begin
      alt     = grp_i[0] ? W_ALT_HI : W_ALT_LO;
      sel_a_o = W_ZERO;
      sel_b_o = W_ZERO;
      unique case (grp_i)
         2'd0: begin
            sel_a_o = step_i[1] ? W_ONE : W_ZERO;
            sel_b_o = step_i[0] ? W_ONE : W_ZERO;
         end
         2'd1: begin
            sel_a_o = step_i[0] ? W_ALT_HI : W_ALT_LO;
            sel_b_o = (step_i[0] ^ step_i[1]) ? W_ALT_HI : W_ALT_LO;
         end
         default: begin
            if (step_i[1]) begin
               sel_a_o = step_i[0] ? W_ZERO : W_ONE;
               sel_b_o = alt;
            end else begin
               sel_a_o = alt;
               sel_b_o = step_i[0] ? W_ONE : W_ZERO;
            end
         end
      endcase
   end
endmodule

// File: rtl/tpg_word_expand.sv
module tpg_word_expand
   import tpg_pkg::*;
#(
   parameter int unsigned OPW = 8
) (
   input  word_sel_e      sel_i,
   output logic [OPW-1:0] word_o
);
   logic is_one, is_lo, is_hi;
   assign is_one = (sel_i == W_ONE);
   assign is_lo  = (sel_i == W_ALT_LO);
   assign is_hi  = (sel_i == W_ALT_HI);

   for (genvar i = 0; i < OPW; i++) begin : g_bit
      if (i % 2 == 0) begin : g_even
         assign word_o[i] = is_one | is_lo;
      end else begin : g_odd
         assign word_o[i] = is_one | is_hi;
      end
   end
endmodule

// File: rtl/arith_pattern_gen.sv
module arith_pattern_gen
   import tpg_pkg::*;
#(
   parameter int unsigned OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             enable_i,
   output logic [OPW-1:0]   op_a_o,
   output logic [OPW-1:0]   op_b_o,
   output logic             valid_o,
   output logic [IDX_W-1:0] index_o,
   output logic             done_o
);
   localparam int unsigned NUM_OPS = 2;

   if (OPW < 4 || (OPW % 2) != 0) begin : g_bad_width
      $error("arith_pattern_gen: OPW must be even and at least 4");
   end

   logic              emit, tail;
   logic [GRP_W-1:0]  grp;
   logic [STEP_W-1:0] step;
   word_sel_e         sel [NUM_OPS];
   logic [OPW-1:0]    word [NUM_OPS];

   tpg_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .enable_i (enable_i),
      .emit_o   (emit),
      .tail_o   (tail),
      .grp_o    (grp),
      .step_o   (step)
   );

   tpg_pair_decoder u_dec (
      .grp_i   (grp),
      .step_i  (step),
      .sel_a_o (sel[0]),
      .sel_b_o (sel[1])
   );

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
      tpg_word_expand #(.OPW(OPW)) u_exp (
         .sel_i  (sel[k]),
         .word_o (word[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_a_o  <= '0;
         op_b_o  <= '0;
         index_o <= '0;
         valid_o <= 1'b0;
         done_o  <= 1'b0;
      end else if (start_i) begin
         op_a_o  <= '0;
         op_b_o  <= '0;
         index_o <= '0;
         valid_o <= 1'b0;
         done_o  <= 1'b0;
      end else if (emit) begin
         op_a_o  <= word[0];
         op_b_o  <= word[1];
         index_o <= {grp, step};
         valid_o <= 1'b1;
      end else if (tail) begin
         op_a_o  <= '0;
         op_b_o  <= '0;
         valid_o <= 1'b0;
         done_o  <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
   import tpg_pkg::*;
#(
   parameter int unsigned OPW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             enable_i,
   input logic [OPW-1:0]   op_a_o,
   input logic [OPW-1:0]   op_b_o,
   input logic             valid_o,
   input logic [IDX_W-1:0] index_o,
   input logic             done_o
);
   localparam logic [OPW-1:0] PAT_P = {(OPW/2){2'b01}};
   localparam logic [OPW-1:0] PAT_Q = {(OPW/2){2'b10}};

   function automatic logic legal(input logic [OPW-1:0] w);
      return (w == '0) || (w == '1) || (w == PAT_P) || (w == PAT_Q);
   endfunction

   assert_start_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!valid_o && !done_o && index_o == '0 && op_a_o == '0 && op_b_o == '0));

   assert_issue_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(enable_i));

   assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o)) |-> (index_o == $past(index_o) + 1'b1));

   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !done_o && !$past(start_i)) |->
         ($stable(op_a_o) && $stable(op_b_o) && $stable(index_o)));

   assert_legal_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (legal(op_a_o) && legal(op_b_o)));

   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(valid_o) && $past(index_o) == 4'd15));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!valid_o && op_a_o == '0 && op_b_o == '0));
endmodule

bind arith_pattern_gen tpg_checker #(.OPW(OPW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .enable_i (enable_i),
   .op_a_o   (op_a_o),
   .op_b_o   (op_b_o),
   .valid_o  (valid_o),
   .index_o  (index_o),
   .done_o   (done_o)
);

// File: tb/tb_arith_pattern_gen.sv
module tb_arith_pattern_gen;
   logic clk = 1'b0;
   logic rst_n, start, en;
   always #4 clk = ~clk;

   logic [7:0]  a8, b8;   logic [3:0] i8;  logic v8, d8;
   logic [3:0]  a4, b4;   logic [3:0] i4;  logic v4, d4;
   logic [15:0] a16, b16; logic [3:0] i16; logic v16, d16;

   arith_pattern_gen #(.OPW(8)) dut (.clk(clk), .rst_n(rst_n), .start_i(start), .enable_i(en),
      .op_a_o(a8), .op_b_o(b8), .valid_o(v8), .index_o(i8), .done_o(d8));
   arith_pattern_gen #(.OPW(4)) dut_w4 (.clk(clk), .rst_n(rst_n), .start_i(start), .enable_i(en),
      .op_a_o(a4), .op_b_o(b4), .valid_o(v4), .index_o(i4), .done_o(d4));
   arith_pattern_gen #(.OPW(16)) dut_w16 (.clk(clk), .rst_n(rst_n), .start_i(start), .enable_i(en),
      .op_a_o(a16), .op_b_o(b16), .valid_o(v16), .index_o(i16), .done_o(d16));

   int total = 0, bad = 0;
   int exp_q[$];
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // codes: 0 zeros, 1 ones, 2 even bits set, 3 odd bits set; {A,B}
   function automatic logic [3:0] pair_code(input int i);
      case (i)
         0: return {2'd0, 2'd0};  1: return {2'd0, 2'd1};
         2: return {2'd1, 2'd0};  3: return {2'd1, 2'd1};
         4: return {2'd2, 2'd2};  5: return {2'd3, 2'd3};
         6: return {2'd2, 2'd3};  7: return {2'd3, 2'd2};
         8: return {2'd2, 2'd0};  9: return {2'd2, 2'd1};
         10: return {2'd1, 2'd2}; 11: return {2'd0, 2'd2};
         12: return {2'd3, 2'd0}; 13: return {2'd3, 2'd1};
         14: return {2'd1, 2'd3}; default: return {2'd0, 2'd3};
      endcase
   endfunction

   function automatic logic [15:0] word(input logic [1:0] c, input int w);
      logic [15:0] r = '0;
      for (int i = 0; i < w; i++)
         r[i] = (c == 2'd1) || (c == 2'd2 && i % 2 == 0) || (c == 2'd3 && i % 2 == 1);
      return r;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished && (v8 || v4 || v16)) begin
         if (exp_q.size() == 0) begin
            chk(0, "R9 unexpected vector", {i8, 3'b0, v8}, 0);
         end else begin
            int e;
            logic [3:0] pc;
            e = exp_q.pop_front();
            pc = pair_code(e);
            chk(v8 && v4 && v16, "R3 valid on all widths", {v4, v8, v16}, 3'b111);
            chk(i8 == e[3:0] && i4 == e[3:0] && i16 == e[3:0], "R8 index",
                {i4, i8, i16}, {3{e[3:0]}});
            chk(a8 == word(pc[3:2], 8) && b8 == word(pc[1:0], 8), "R5 R6 pair w8",
                {a8, b8}, {word(pc[3:2], 8)[7:0], word(pc[1:0], 8)[7:0]});
            chk(a4 == word(pc[3:2], 4) && b4 == word(pc[1:0], 4), "R5 R6 pair w4",
                {a4, b4}, {word(pc[3:2], 4)[3:0], word(pc[1:0], 4)[3:0]});
            chk(a16 == word(pc[3:2], 16) && b16 == word(pc[1:0], 16), "R5 R6 pair w16",
                {a16, b16}, {word(pc[3:2], 16), word(pc[1:0], 16)});
         end
      end
   end

   task automatic push_all(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(i);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_done(input string tag);
      chk(d8 && d4 && d16, {tag, " done high"}, {d4, d8, d16}, 3'b111);
      chk(!v8 && a8 == 0 && b8 == 0 && a16 == 0 && b16 == 0 && a4 == 0 && b4 == 0,
          {tag, " quiet at done"}, {v8, a8, b8}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; en = 1'b0;
      repeat (3) @(negedge clk);
      chk(a8 == 0 && b8 == 0 && i8 == 0 && !v8 && !d8, "R1 reset state", {a8, b8, i8, v8, d8}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(a16 == 0 && b16 == 0 && i16 == 0 && !v16 && !d16, "R1 after reset", {a16, b16, i16}, 0);

      // R9: enable before any start issues nothing
      en = 1'b1;
      repeat (5) @(negedge clk);
      chk(!v8 && !d8 && i8 == 0, "R9 enable before start", {v8, d8, i8}, 0);
      en = 1'b0;

      // full run, R5 R7
      pulse_start();
      chk(!v8 && !d8 && i8 == 0, "R2 quiet after start", {v8, d8, i8}, 0);
      push_all(16);
      en = 1'b1;
      repeat (16) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check_done("R7 full run");
      chk(exp_q.size() == 0, "R5 all sixteen issued", exp_q.size(), 0);
      en = 1'b1;
      repeat (4) @(negedge clk);
      chk(d8 && !v8, "R9 enable after done", {d8, v8}, 2'b10);
      en = 1'b0;

      // enable gaps, R4
      pulse_start();
      push_all(16);
      for (int n = 1; n <= 16; n++) begin
         logic [7:0] sa, sb; logic [3:0] si;
         en = 1'b1;
         @(negedge clk);
         if (n % 5 == 0) begin
            en = 1'b0;
            sa = a8; sb = b8; si = i8;
            repeat (2) @(negedge clk);
            chk(!v8 && a8 == sa && b8 == sb && i8 == si, "R4 hold during gap",
                {v8, a8, b8, i8}, {1'b0, sa, sb, si});
         end
      end
      en = 1'b0;
      @(negedge clk);
      check_done("R7 gapped run");

      // mid-sequence restart with enable high, R2
      pulse_start();
      push_all(6);
      en = 1'b1;
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      en = 1'b0;
      chk(!v8 && !d8 && i8 == 0 && a8 == 0 && b8 == 0, "R2 mid-sequence rewind",
          {v8, d8, i8, a8, b8}, 0);
      chk(exp_q.size() == 0, "R2 no leftover pair", exp_q.size(), 0);
      push_all(16);
      en = 1'b1;
      repeat (16) @(negedge clk);
      @(negedge clk);
      check_done("R7 after rewind");
      en = 1'b0;
      chk(exp_q.size() == 0, "R2 rerun complete", exp_q.size(), 0);

      repeat (2) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule